// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block holds the pending and in-service state of two chained eight-line interrupt controllers, a primary and a secondary. The secondary reports through line 2 of the primary. Single-cycle request pulses on sixteen lines are filtered against masks and against lines already in service. Accepted requests are latched as pending, and the CPU interrupt output is raised. When the CPU acknowledges, the block picks the highest-priority pending line and presents its 8-bit vector in the same cycle. At the next clock edge it moves that line from pending to in service.

Programming of the configuration is done elsewhere. Masks, vector bases, cascade bytes and auto-EOI flags arrive as static inputs. End-of-interrupt commands arrive as per-controller clear masks. The pending and in-service registers are brought out so that the programming interface can read them.

Top module: `irq_cascade_resolver`

## Requirements
- R1: A pulse on line n (0..7) that is neither masked nor blocked sets bit n of `mst_irr` at the next edge, and `cpu_int` is high from that edge.
- R2: A primary request is dropped and leaves `mst_irr` unchanged in either of two cases. The first is when `mst_mask[n]` is 1. The second is when any bit of `mst_isr` at index n or below is set.
- R3: Pulses on lines 8..15 (secondary line n-8) are ignored unless `mst_casc[2]` is 1 and `slv_casc` equals 8'h02.
- R4: When the cascade check of R3 passes, a secondary request on line s is still dropped in three cases: any `mst_isr` bit is set, any `slv_isr` bit at index s or below is set, or `slv_mask[s]` is 1.
- R5: An accepted secondary request on line s sets `slv_irr[s]` and raises `cpu_int`. It also sets `mst_isr[2]` unless `mst_aeoi` is 1.
- R6: While `ack_strobe` is high, the winner is chosen in this order. Primary lines 0 and 1 come first. Next come secondary lines 0, 2, 3 .. 7, but only if the cascade check of R3 passes. Secondary line 1 is never chosen. Primary lines 2 .. 7 come last.
- R7: The winning line has its pending bit cleared at the next edge. Its in-service bit is set unless that controller's auto-EOI flag is 1. `vector_out` equals (controller base + line index) mod 256 during the acknowledge cycle and is 0 when `ack_strobe` is low.
- R8: An acknowledge with no eligible pending line returns (`slv_offset` + 7) mod 256 when `mst_isr[2]` is set, and (`mst_offset` + 7) mod 256 otherwise. No state changes.
- R9: `cpu_int` falls after an acknowledge cycle that leaves both pending registers empty and accepts no new request. Otherwise it holds its value, or rises as R1 and R5 describe.
- R10: Each bit set in `mst_eoi_clr` or `slv_eoi_clr` clears that in-service bit at the next edge. An in-service bit set by an acknowledge or by R5 in the same cycle wins. Requests are judged against the state before the edge, so a request on the line being acknowledged leaves its pending bit set.
- R11: After reset, all four registers are zero and `cpu_int` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_pulse | input | 16 | Request pulses, bits 0..7 primary, 8..15 secondary |
| ack_strobe | input | 1 | CPU acknowledge, one cycle per vector |
| mst_mask | input | 8 | Primary mask, 1 blocks the line |
| slv_mask | input | 8 | Secondary mask, 1 blocks the line |
| mst_offset | input | 8 | Primary vector base |
| slv_offset | input | 8 | Secondary vector base |
| mst_casc | input | 8 | Primary cascade byte |
| slv_casc | input | 8 | Secondary cascade byte |
| mst_aeoi | input | 1 | Primary auto-EOI |
| slv_aeoi | input | 1 | Secondary auto-EOI |
| mst_eoi_clr | input | 8 | Primary in-service clear mask |
| slv_eoi_clr | input | 8 | Secondary in-service clear mask |
| cpu_int | output | 1 | Interrupt to CPU |
| vector_out | output | 8 | Vector during acknowledge |
| mst_irr | output | 8 | Primary pending register |
| mst_isr | output | 8 | Primary in-service register |
| slv_irr | output | 8 | Secondary pending register |
| slv_isr | output | 8 | Secondary in-service register |

## Verification
Any corruption of a pending or in-service bit shows up on the register outputs one edge after the stimulus that caused it. A wrong in-service bit also changes which later requests are accepted. A wrong priority decision shows in `vector_out` in the very acknowledge cycle, and as a wrong bit cleared one edge later. A stray or missing `mst_isr[2]` mark shows as a changed spurious vector and as primary requests on higher lines being dropped or accepted wrongly.

// File: rtl/irq_cascade_pkg.sv
`timescale 1ns/1ps
package irq_cascade_pkg;
  localparam int IRQ_LINES = 8;
  localparam int IDX_W     = $clog2(IRQ_LINES);
  localparam int VEC_W     = 8;
  localparam int CASC_LINE = 2;
  localparam int SLV_SKIP  = 1;
  localparam int SPUR_LINE = IRQ_LINES - 1;

  typedef logic [IRQ_LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0]     line_idx_t;
  typedef logic [VEC_W-1:0]     vec_t;

  typedef struct packed {
    logic      found;
    line_idx_t idx;
  } pick_t;

  // true when a line at idx or below is in service
  function automatic logic isr_blocks(line_vec_t isr, line_idx_t idx);
    line_vec_t low;
    low = (line_vec_t'(2) << idx) - line_vec_t'(1);
    return |(isr & low);
  endfunction

  function automatic vec_t vec_of(vec_t base, line_idx_t idx);
    return base + vec_t'(idx);
  endfunction

  function automatic logic cascade_ok(vec_t mcasc, vec_t scasc);
    return mcasc[CASC_LINE] && (scasc == vec_t'(CASC_LINE));
  endfunction

  // lowest set bit of bits that is not excluded
  function automatic pick_t pick_lowest(line_vec_t bits, line_vec_t excl);
    pick_t p;
    p = '0;
    for (int k = IRQ_LINES - 1; k >= 0; k--) begin
      if (bits[k] && !excl[k]) begin
        p.found = 1'b1;
        p.idx   = line_idx_t'(k);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/irq_req_gate.sv
`timescale 1ns/1ps
module irq_req_gate
  import irq_cascade_pkg::*;
(
  input  line_vec_t mst_req,
  input  line_vec_t slv_req,
  input  line_vec_t mst_isr,
  input  line_vec_t slv_isr,
  input  line_vec_t mst_mask,
  input  line_vec_t slv_mask,
  input  logic      casc_ok,
  input  logic      mst_aeoi,
  output line_vec_t mst_irr_set,
  output line_vec_t slv_irr_set,
  output logic      mst_isr_casc_set,
  output logic      any_accept
);
  logic mst_busy;
  assign mst_busy = |mst_isr;

  generate
    for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
      assign mst_irr_set[g] = mst_req[g] & ~mst_mask[g]
                              & ~isr_blocks(mst_isr, line_idx_t'(g));
      assign slv_irr_set[g] = slv_req[g] & casc_ok & ~mst_busy & ~slv_mask[g]
                              & ~isr_blocks(slv_isr, line_idx_t'(g));
    end
  endgenerate

  assign mst_isr_casc_set = (|slv_irr_set) & ~mst_aeoi;
  assign any_accept       = (|mst_irr_set) | (|slv_irr_set);
endmodule

// File: rtl/irq_ack_arbiter.sv
`timescale 1ns/1ps
module irq_ack_arbiter
  import irq_cascade_pkg::*;
(
  input  logic      ack,
  input  logic      casc_ok,
  input  line_vec_t mst_irr,
  input  line_vec_t slv_irr,
  input  line_vec_t mst_isr,
  input  vec_t      mst_offset,
  input  vec_t      slv_offset,
  input  logic      mst_aeoi,
  input  logic      slv_aeoi,
  output line_vec_t mst_irr_clr,
  output line_vec_t slv_irr_clr,
  output line_vec_t mst_isr_set,
  output line_vec_t slv_isr_set,
  output logic      win_valid,
  output vec_t      win_vec
);
  localparam line_vec_t SKIP_MASK  = line_vec_t'(1) << SLV_SKIP;
  localparam line_vec_t UPPER_MASK = ~((line_vec_t'(1) << CASC_LINE) - line_vec_t'(1));

  pick_t mst_hi, mst_lo, slv_p;
  assign mst_hi = pick_lowest(mst_irr, UPPER_MASK);
  assign mst_lo = pick_lowest(mst_irr, ~UPPER_MASK);
  assign slv_p  = pick_lowest(slv_irr, SKIP_MASK);

  always_comb begin
    mst_irr_clr = '0;
    slv_irr_clr = '0;
    mst_isr_set = '0;
    slv_isr_set = '0;
    win_valid   = 1'b0;
    win_vec     = '0;
    if (mst_hi.found) begin
      win_valid                 = 1'b1;
      mst_irr_clr[mst_hi.idx]   = 1'b1;
      mst_isr_set[mst_hi.idx]   = ~mst_aeoi;
      win_vec                   = vec_of(mst_offset, mst_hi.idx);
    end else if (casc_ok && slv_p.found) begin
      win_valid                 = 1'b1;
      slv_irr_clr[slv_p.idx]    = 1'b1;
      slv_isr_set[slv_p.idx]    = ~slv_aeoi;
      win_vec                   = vec_of(slv_offset, slv_p.idx);
    end else if (mst_lo.found) begin
      win_valid                 = 1'b1;
      mst_irr_clr[mst_lo.idx]   = 1'b1;
      mst_isr_set[mst_lo.idx]   = ~mst_aeoi;
      win_vec                   = vec_of(mst_offset, mst_lo.idx);
    end else begin
      win_vec = mst_isr[CASC_LINE] ? vec_of(slv_offset, line_idx_t'(SPUR_LINE))
                                   : vec_of(mst_offset, line_idx_t'(SPUR_LINE));
    end
    if (!ack) begin
      mst_irr_clr = '0;
      slv_irr_clr = '0;
      mst_isr_set = '0;
      slv_isr_set = '0;
      win_valid   = 1'b0;
      win_vec     = '0;
    end
  end
endmodule

// File: rtl/irq_ctrl_bank.sv
`timescale 1ns/1ps
module irq_ctrl_bank
  import irq_cascade_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irr_set,
  input  line_vec_t irr_clr,
  input  line_vec_t isr_set,
  input  line_vec_t isr_clr,
  output line_vec_t irr_q,
  output line_vec_t isr_q,
  output line_vec_t irr_next
);
  line_vec_t isr_next;
  // sets win over clears on both registers
  assign irr_next = (irr_q & ~irr_clr) | irr_set;
  assign isr_next = (isr_q & ~isr_clr) | isr_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irr_next;
      isr_q <= isr_next;
    end
  end
endmodule

// File: rtl/irq_cascade_resolver.sv
`timescale 1ns/1ps
module irq_cascade_resolver
  import irq_cascade_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*IRQ_LINES-1:0] req_pulse,
  input  logic                   ack_strobe,
  input  logic [IRQ_LINES-1:0]   mst_mask,
  input  logic [IRQ_LINES-1:0]   slv_mask,
  input  logic [VEC_W-1:0]       mst_offset,
  input  logic [VEC_W-1:0]       slv_offset,
  input  logic [VEC_W-1:0]       mst_casc,
  input  logic [VEC_W-1:0]       slv_casc,
  input  logic                   mst_aeoi,
  input  logic                   slv_aeoi,
  input  logic [IRQ_LINES-1:0]   mst_eoi_clr,
  input  logic [IRQ_LINES-1:0]   slv_eoi_clr,
  output logic                   cpu_int,
  output logic [VEC_W-1:0]       vector_out,
  output logic [IRQ_LINES-1:0]   mst_irr,
  output logic [IRQ_LINES-1:0]   mst_isr,
  output logic [IRQ_LINES-1:0]   slv_irr,
  output logic [IRQ_LINES-1:0]   slv_isr
);
  logic      casc_ok;
  line_vec_t mst_irr_set, slv_irr_set;
  logic      mst_isr_casc_set, any_accept;
  line_vec_t arb_mst_irr_clr, arb_slv_irr_clr, arb_mst_isr_set, arb_slv_isr_set;
  logic      win_valid;
  vec_t      win_vec;
  line_vec_t mst_isr_set_all;
  line_vec_t mst_irr_next, slv_irr_next;
  logic      int_q;

  assign casc_ok = cascade_ok(mst_casc, slv_casc);

  irq_req_gate u_gate (
    .mst_req          (req_pulse[IRQ_LINES-1:0]),
    .slv_req          (req_pulse[2*IRQ_LINES-1:IRQ_LINES]),
    .mst_isr          (mst_isr),
    .slv_isr          (slv_isr),
    .mst_mask         (mst_mask),
    .slv_mask         (slv_mask),
    .casc_ok          (casc_ok),
    .mst_aeoi         (mst_aeoi),
    .mst_irr_set      (mst_irr_set),
    .slv_irr_set      (slv_irr_set),
    .mst_isr_casc_set (mst_isr_casc_set),
    .any_accept       (any_accept)
  );

  irq_ack_arbiter u_arb (
    .ack         (ack_strobe),
    .casc_ok     (casc_ok),
    .mst_irr     (mst_irr),
    .slv_irr     (slv_irr),
    .mst_isr     (mst_isr),
    .mst_offset  (mst_offset),
    .slv_offset  (slv_offset),
    .mst_aeoi    (mst_aeoi),
    .slv_aeoi    (slv_aeoi),
    .mst_irr_clr (arb_mst_irr_clr),
    .slv_irr_clr (arb_slv_irr_clr),
    .mst_isr_set (arb_mst_isr_set),
    .slv_isr_set (arb_slv_isr_set),
    .win_valid   (win_valid),
    .win_vec     (win_vec)
  );

  assign mst_isr_set_all = arb_mst_isr_set | (line_vec_t'(mst_isr_casc_set) << CASC_LINE);

  irq_ctrl_bank u_mst (
    .clk      (clk),
    .rst_n    (rst_n),
    .irr_set  (mst_irr_set),
    .irr_clr  (arb_mst_irr_clr),
    .isr_set  (mst_isr_set_all),
    .isr_clr  (mst_eoi_clr),
    .irr_q    (mst_irr),
    .isr_q    (mst_isr),
    .irr_next (mst_irr_next)
  );

  irq_ctrl_bank u_slv (
    .clk      (clk),
    .rst_n    (rst_n),
    .irr_set  (slv_irr_set),
    .irr_clr  (arb_slv_irr_clr),
    .isr_set  (arb_slv_isr_set),
    .isr_clr  (slv_eoi_clr),
    .irr_q    (slv_irr),
    .isr_q    (slv_isr),
    .irr_next (slv_irr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q <= 1'b0;
    end else if (any_accept) begin
      int_q <= 1'b1;
    end else if (ack_strobe && (mst_irr_next == '0) && (slv_irr_next == '0)) begin
      int_q <= 1'b0;
    end
  end

  assign cpu_int    = int_q;
  assign vector_out = win_vec;
endmodule

// File: rtl/irq_cascade_resolver_chk.sv
`timescale 1ns/1ps
module irq_cascade_resolver_chk
  import irq_cascade_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*IRQ_LINES-1:0] req_pulse,
  input logic                   ack_strobe,
  input logic [IRQ_LINES-1:0]   mst_mask,
  input logic [VEC_W-1:0]       slv_offset,
  input logic [VEC_W-1:0]       mst_casc,
  input logic [VEC_W-1:0]       slv_casc,
  input logic                   mst_aeoi,
  input logic                   cpu_int,
  input logic [VEC_W-1:0]       vector_out,
  input logic [IRQ_LINES-1:0]   mst_irr,
  input logic [IRQ_LINES-1:0]   mst_isr,
  input logic [IRQ_LINES-1:0]   slv_irr,
  input logic                   any_accept,
  input logic [IRQ_LINES-1:0]   slv_irr_set,
  input logic [IRQ_LINES-1:0]   arb_mst_irr_clr,
  input logic [IRQ_LINES-1:0]   arb_slv_irr_clr,
  input logic [IRQ_LINES-1:0]   arb_mst_isr_set
);
  a_r1_int_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    any_accept |=> cpu_int);

  a_r2_masked_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_strobe && mst_irr == '0 && (req_pulse[IRQ_LINES-1:0] & ~mst_mask) == '0)
    |=> mst_irr == '0);

  a_r3_no_cascade_no_slave: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mst_casc[CASC_LINE] && slv_casc == VEC_W'(CASC_LINE)) && slv_irr == '0)
    |=> slv_irr == '0);

  a_r5_slave_marks_master: assert property (@(posedge clk) disable iff (!rst_n)
    ((|slv_irr_set) && !mst_aeoi) |=> mst_isr[CASC_LINE]);

  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arb_mst_irr_clr, arb_slv_irr_clr}));

  a_r8_spurious_slave_base: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && mst_irr == '0 && slv_irr == '0 && mst_isr[CASC_LINE])
    |-> vector_out == VEC_W'(slv_offset + VEC_W'(SPUR_LINE)));

  a_r9_int_covers_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_int |-> (mst_irr == '0 && slv_irr == '0));

  a_r10_set_beats_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (|arb_mst_isr_set) |=> ((mst_isr & $past(arb_mst_isr_set)) == $past(arb_mst_isr_set)));
endmodule

bind irq_cascade_resolver irq_cascade_resolver_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_pulse       (req_pulse),
  .ack_strobe      (ack_strobe),
  .mst_mask        (mst_mask),
  .slv_offset      (slv_offset),
  .mst_casc        (mst_casc),
  .slv_casc        (slv_casc),
  .mst_aeoi        (mst_aeoi),
  .cpu_int         (cpu_int),
  .vector_out      (vector_out),
  .mst_irr         (mst_irr),
  .mst_isr         (mst_isr),
  .slv_irr         (slv_irr),
  .any_accept      (any_accept),
  .slv_irr_set     (slv_irr_set),
  .arb_mst_irr_clr (arb_mst_irr_clr),
  .arb_slv_irr_clr (arb_slv_irr_clr),
  .arb_mst_isr_set (arb_mst_isr_set)
);

// File: tb/irq_cascade_resolver_tb_top.sv
`timescale 1ns/1ps
module irq_cascade_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_pulse = '0;
  logic        ack_strobe = 1'b0;
  logic [7:0]  mst_mask = '0, slv_mask = '0;
  logic [7:0]  mst_offset = 8'h08, slv_offset = 8'hF9;
  logic [7:0]  mst_casc = 8'h04, slv_casc = 8'h02;
  logic        mst_aeoi = 1'b0, slv_aeoi = 1'b0;
  logic [7:0]  mst_eoi_clr = '0, slv_eoi_clr = '0;
  logic        cpu_int;
  logic [7:0]  vector_out, mst_irr, mst_isr, slv_irr, slv_isr;

  always #2.5 clk = ~clk;

  irq_cascade_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_pulse(req_pulse), .ack_strobe(ack_strobe),
    .mst_mask(mst_mask), .slv_mask(slv_mask), .mst_offset(mst_offset),
    .slv_offset(slv_offset), .mst_casc(mst_casc), .slv_casc(slv_casc),
    .mst_aeoi(mst_aeoi), .slv_aeoi(slv_aeoi), .mst_eoi_clr(mst_eoi_clr),
    .slv_eoi_clr(slv_eoi_clr), .cpu_int(cpu_int), .vector_out(vector_out),
    .mst_irr(mst_irr), .mst_isr(mst_isr), .slv_irr(slv_irr), .slv_isr(slv_isr)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m_mirr = '0, m_misr = '0, m_sirr = '0, m_sisr = '0;
  logic       m_int = 1'b0;

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_pulse = '0; ack_strobe = 1'b0; mst_eoi_clr = '0; slv_eoi_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_mirr = '0; m_misr = '0; m_sirr = '0; m_sisr = '0; m_int = 1'b0;
    #1;
    chk("R11", "mst_irr", mst_irr, 8'h00);
    chk("R11", "mst_isr", mst_isr, 8'h00);
    chk("R11", "slv_irr", slv_irr, 8'h00);
    chk("R11", "slv_isr", slv_isr, 8'h00);
    chk("R11", "cpu_int", {7'd0, cpu_int}, 8'h00);
  endtask

  // one clock of stimulus, checked against the bench model
  task automatic step(input logic [15:0] req, input logic ack,
                      input logic [7:0] meoi, input logic [7:0] seoi, input string tag);
    bit casc, found, who, blk, s_acc, any_acc;
    int idx, vec;
    logic [7:0] n_mirr, n_misr, n_sirr, n_sisr;
    @(negedge clk);
    req_pulse = req; ack_strobe = ack; mst_eoi_clr = meoi; slv_eoi_clr = seoi;
    #1;
    casc = mst_casc[2] && (slv_casc == 8'd2);
    found = 0; who = 0; idx = 0;
    for (int i = 0; i < 8 && !found; i++) begin
      if (i == 2 && casc)
        for (int j = 0; j < 8 && !found; j++)
          if (j != 1 && m_sirr[j]) begin found = 1; who = 1; idx = j; end
      if (!found && m_mirr[i]) begin found = 1; who = 0; idx = i; end
    end
    if (found) vec = (who ? int'(slv_offset) : int'(mst_offset)) + idx;
    else vec = (m_misr[2] ? int'(slv_offset) : int'(mst_offset)) + 7;
    vec = vec % 256;
    if (ack) chk(tag, "vector_out", vector_out, 8'(vec));
    else chk(tag, "vector_out idle", vector_out, 8'h00);
    n_mirr = m_mirr; n_sirr = m_sirr;
    n_misr = m_misr & ~meoi; n_sisr = m_sisr & ~seoi;
    if (ack && found) begin
      if (who) begin n_sirr[idx] = 1'b0; if (!slv_aeoi) n_sisr[idx] = 1'b1; end
      else begin n_mirr[idx] = 1'b0; if (!mst_aeoi) n_misr[idx] = 1'b1; end
    end
    any_acc = 0; s_acc = 0;
    for (int n = 0; n < 8; n++) begin
      blk = 0;
      for (int k = 0; k <= n; k++) if (m_misr[k]) blk = 1;
      if (req[n] && !mst_mask[n] && !blk) begin n_mirr[n] = 1'b1; any_acc = 1; end
      blk = (m_misr != 8'h00);
      for (int k = 0; k <= n; k++) if (m_sisr[k]) blk = 1;
      if (req[n+8] && casc && !slv_mask[n] && !blk) begin
        n_sirr[n] = 1'b1; any_acc = 1; s_acc = 1;
      end
    end
    if (s_acc && !mst_aeoi) n_misr[2] = 1'b1;
    @(posedge clk);
    #1;
    req_pulse = '0; ack_strobe = 1'b0; mst_eoi_clr = '0; slv_eoi_clr = '0;
    if (any_acc) m_int = 1'b1;
    else if (ack && n_mirr == 8'h00 && n_sirr == 8'h00) m_int = 1'b0;
    m_mirr = n_mirr; m_misr = n_misr; m_sirr = n_sirr; m_sisr = n_sisr;
    chk(tag, "mst_irr", mst_irr, m_mirr);
    chk(tag, "mst_isr", mst_isr, m_misr);
    chk(tag, "slv_irr", slv_irr, m_sirr);
    chk(tag, "slv_isr", slv_isr, m_sisr);
    chk(tag, "cpu_int", {7'd0, cpu_int}, {7'd0, m_int});
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rng;
    do_reset();

    // R1 and R7: each primary line alone, then retired
    for (int n = 0; n < 8; n++) begin
      step(16'(1 << n), 1'b0, 8'h00, 8'h00, "R1");
      step(16'h0000, 1'b1, 8'h00, 8'h00, "R7");
      step(16'h0000, 1'b0, 8'hFF, 8'h00, "R10");
    end
    // R2: masked line dropped, then spurious acknowledge on the primary base
    for (int n = 0; n < 8; n++) begin
      mst_mask = 8'(1 << n);
      step(16'(1 << n), 1'b0, 8'h00, 8'h00, "R2");
      step(16'h0000, 1'b1, 8'h00, 8'h00, "R8");
    end
    mst_mask = 8'h00;
    // R2: blocking by an in-service line at or below the index
    step(16'h0008, 1'b0, 8'h00, 8'h00, "R1");
    step(16'h0000, 1'b1, 8'h00, 8'h00, "R7");
    step(16'h0020, 1'b0, 8'h00, 8'h00, "R2");
    step(16'h0008, 1'b0, 8'h00, 8'h00, "R2");
    step(16'h0002, 1'b0, 8'h00, 8'h00, "R1");
    do_reset();
    // R5 and R6: secondary lines through the cascade
    for (int s = 0; s < 8; s++) begin
      if (s != 1) begin
        step(16'(1 << (s + 8)), 1'b0, 8'h00, 8'h00, "R5");
        step(16'h0000, 1'b1, 8'h00, 8'h00, "R6");
        step(16'h0000, 1'b0, 8'hFF, 8'hFF, "R10");
      end
    end
    // R3: cascade bytes disagree
    slv_casc = 8'h03;
    step(16'hFF00, 1'b0, 8'h00, 8'h00, "R3");
    mst_casc = 8'h00; slv_casc = 8'h02;
    step(16'hFF00, 1'b0, 8'h00, 8'h00, "R3");
    mst_casc = 8'h04;
    // R4: primary in service blocks secondary
    step(16'h0040, 1'b0, 8'h00, 8'h00, "R1");
    step(16'h0000, 1'b1, 8'h00, 8'h00, "R7");
    step(16'h0100, 1'b0, 8'h00, 8'h00, "R4");
    step(16'h0000, 1'b0, 8'hFF, 8'h00, "R10");
    slv_mask = 8'h08;
    step(16'h0800, 1'b0, 8'h00, 8'h00, "R4");
    slv_mask = 8'h00;
    mst_aeoi = 1'b1;
    step(16'h1000, 1'b0, 8'h00, 8'h00, "R5");
    step(16'h0000, 1'b1, 8'h00, 8'h00, "R6");
    step(16'h4000, 1'b0, 8'h00, 8'h00, "R4");
    step(16'h0400, 1'b0, 8'h00, 8'h00, "R4");
    mst_aeoi = 1'b0;
    do_reset();
    // R6: mixed priority, secondary nested at line 2
    slv_aeoi = 1'b1;
    step(16'h0089, 1'b0, 8'h00, 8'h00, "R1");
    step(16'h2000, 1'b0, 8'h00, 8'h00, "R5");
    for (int a = 0; a < 4; a++) step(16'h0000, 1'b1, 8'h00, 8'h00, "R6");
    step(16'h0000, 1'b1, 8'h00, 8'h00, "R8");
    step(16'h0000, 1'b0, 8'hFF, 8'hFF, "R10");
    step(16'h0000, 1'b1, 8'h00, 8'h00, "R8");
    slv_aeoi = 1'b0;
    // R7: auto-EOI leaves in-service empty
    mst_aeoi = 1'b1; slv_aeoi = 1'b1;
    step(16'h0010, 1'b0, 8'h00, 8'h00, "R7");
    step(16'h0000, 1'b1, 8'h00, 8'h00, "R7");
    mst_aeoi = 1'b0; slv_aeoi = 1'b0;
    do_reset();
    // R10: EOI colliding with acknowledge and a same-line request
    step(16'h0002, 1'b0, 8'h00, 8'h00, "R1");
    step(16'h0000, 1'b1, 8'h00, 8'h00, "R7");
    step(16'h0001, 1'b0, 8'h00, 8'h00, "R1");
    step(16'h0001, 1'b1, 8'hFF, 8'h00, "R10");
    step(16'h0000, 1'b1, 8'hFF, 8'h00, "R9");
    do_reset();
    // R6 and R9: secondary line 1 is never chosen
    step(16'h0200, 1'b0, 8'h00, 8'h00, "R5");
    step(16'h0000, 1'b1, 8'h00, 8'h00, "R6");
    step(16'h0000, 1'b1, 8'hFF, 8'hFF, "R9");
    do_reset();
    // sweep of mixed traffic against the model
    rng = 32'h1234_5678;
    for (int t = 0; t < 600; t++) begin
      rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
      if (t % 60 == 0) begin
        mst_mask = rng[7:0] & rng[15:8];
        slv_mask = rng[23:16] & rng[31:24];
        mst_aeoi = rng[3]; slv_aeoi = rng[9];
        mst_offset = rng[31:24]; slv_offset = rng[15:8] | 8'hF8;
        mst_casc = rng[5] ? 8'h04 : 8'h05;
        slv_casc = rng[6] ? 8'h02 : 8'h02 ^ {7'd0, rng[12]};
        if (t % 180 == 0) do_reset();
      end
      step(rng[15:0] & rng[31:16], rng[20], rng[27] ? rng[23:16] : 8'h00,
           rng[28] ? rng[31:24] : 8'h00, rng[20] ? "R6" : "R10");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule